// File: doc/BRIEF.md
# Printer Port Host Register Interface

This block sits between a host register bus and the pins of a byte-wide printer port. It offers two host-visible locations. Offset 0 holds an output byte that drives the port data pins. Offset 1 returns a status byte built from the printer status inputs and a sticky transfer-timeout flag. The block runs in either compatible mode or enhanced (EPP) mode. In compatible mode a read of offset 0 returns the live levels on the data pins. In enhanced mode it returns the stored byte.

In enhanced mode a cycle counter measures each peripheral transfer. The counter starts when a transfer begins and stops when the peripheral acknowledges. If the acknowledge does not arrive within the configured time (10 µs at the configured clock), the counter sets the timeout flag. A select input chooses how the flag is cleared. With the select low, software writes a one to bit 0 of the status location. With the select high, the flag clears by itself once a status read ends. The status byte is captured in the first cycle of a read and held for as long as the read lasts.

Top module: `lpt_host_if`

## Requirements
- R1: After reset the output byte on `port_data_o` is 0x00 and the timeout flag (status bit 0) is 0.
- R2: A write (`bus_sel_i`, `bus_wr_i`) to offset 0 stores `bus_wdata_i` at the clock edge. The stored byte appears unchanged on `port_data_o` from that edge on.
- R3: A read of offset 0 returns `port_data_i` combinationally when `enh_mode_i` is 0. It returns the stored output byte when `enh_mode_i` is 1.
- R4: A status read (offset 1, held for one or more cycles) returns the status value of its first cycle for every cycle of the read, even if the inputs change meanwhile.
- R5: The status byte is: bit 0 the timeout flag; bits 1 and 2 always 0; bit 3 `err_n_i`; bit 4 `online_i`; bit 5 `paper_out_i`; bit 6 `ack_n_i`; bit 7 `busy_i`. Each of the five inputs passes through a two-flop synchronizer. A change applied before an edge is therefore seen after the second edge and not after the first.
- R6: With `enh_mode_i` at 1, a `xfer_start_i` pulse at edge E0 sets the flag at edge E(N), where N = CLK_KHZ*TIMEOUT_US/1000 (2000 by default). The flag is still 0 after edge E(N-1). A `periph_ack_i` before that point cancels the timeout. With `enh_mode_i` at 0, `xfer_start_i` is ignored.
- R7: With `auto_clr_sel_i` at 0, writing 1 to bit 0 at offset 1 clears the flag. Writing 0 has no effect, and status reads do not clear it.
- R8: With `auto_clr_sel_i` at 1, the flag clears at the edge after the last cycle of a status read. Writes to bit 0 have no effect.
- R9: If the timeout fires in the same cycle as a clear request, the flag ends up set.
- R10: Offsets other than 0 and 1 ignore writes and read as 0x00. `bus_rdata_o` is 0x00 whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enh_mode_i | input | 1 | 0 = compatible mode, 1 = enhanced (EPP) mode |
| auto_clr_sel_i | input | 1 | Timeout clear rule: 0 = write-one, 1 = end of status read |
| bus_sel_i | input | 1 | Host access select |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe, held for the whole read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| port_data_o | output | 8 | Stored byte driven toward the data pins |
| port_data_i | input | 8 | Live data pin levels |
| err_n_i | input | 1 | Printer error, low active |
| online_i | input | 1 | Printer selected / on line |
| paper_out_i | input | 1 | Paper end |
| ack_n_i | input | 1 | Acknowledge level, low active |
| busy_i | input | 1 | Busy level |
| xfer_start_i | input | 1 | Enhanced-mode transfer begins (pulse) |
| periph_ack_i | input | 1 | Peripheral acknowledged the transfer (pulse) |

## Verification
Two tables drive the main functions. The first pairs written bytes with pin levels that differ from them, in both modes, so a read of offset 0 shows whether it returned the pins or the stored byte. The second sets the five status inputs to asymmetric patterns that expose any swapped or inverted bit. The timeout is probed exactly one cycle before and at its terminal edge. It is then crossed with each clear rule, with a useless write, and with a clear that lands on the set cycle. A status read is held while its inputs change, which tells a frozen snapshot apart from a live view.

// File: rtl/lpt_pkg.sv
// Shared offsets and status layout for the printer port host interface.
// Assumes an 8-bit host data bus.
package lpt_pkg;
    localparam int BYTE_W   = 8;
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int NUM_STAT_IN = 5;

    // Status byte, MSB first; bit positions are host-visible.
    typedef struct packed {
        logic       busy;
        logic       ack_n;
        logic       paper_out;
        logic       online;
        logic       err_n;
        logic [1:0] zero;
        logic       tmo;
    } stat_t;
endpackage

// File: rtl/lpt_sync.sv
// Multi-stage synchronizer for asynchronous status pins.
// Assumes each bit is independent (no bus coherence required).
module lpt_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            // Later stages resample the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lpt_timeout.sv
// Enhanced-mode transfer timer and sticky timeout flag.
// Assumes start/ack are single-cycle pulses in the clk domain.
// A timeout that fires together with a clear leaves the flag set.
module lpt_timeout #(
    parameter int TO_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enh_i,
    input  logic start_i,
    input  logic ack_i,
    input  logic clr_i,
    output logic flag_o
);
    localparam int CNT_W = $clog2(TO_CYCLES + 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = enh_i && active_q && !ack_i && (cnt_q == CNT_W'(TO_CYCLES - 1));

    // Run the counter from transfer start until ack, timeout or mode exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!enh_i || ack_i || hit) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // Sticky flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (hit)   flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assert_flag_needs_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(active_q));
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_i) |=> flag_o);
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_o);
    assert_no_count_compat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_i |=> !active_q);
endmodule

// File: rtl/lpt_stat_cap.sv
// Status read snapshot: passes the live status in the first read cycle,
// then holds that value until the read ends. Flags the read's trailing edge.
module lpt_stat_cap
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] live_i,
    output logic [BYTE_W-1:0] view_o,
    output logic              trail_o
);
    logic              rd_q;
    logic [BYTE_W-1:0] snap_q;

    // Remember read activity and capture the first-cycle value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            snap_q <= '0;
        end else begin
            rd_q <= rd_i;
            if (rd_i && !rd_q) snap_q <= live_i;
        end
    end

    assign view_o  = rd_q ? snap_q : live_i;
    assign trail_o = rd_q && !rd_i;

    assert_read_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rd_q) |-> $stable(view_o));
endmodule

// File: rtl/lpt_host_if.sv
// Host register interface of a byte-wide printer port.
// Offset 0: output byte; offset 1: status with sticky timeout flag.
// Assumes single-cycle writes and reads held for their full duration.
module lpt_host_if
    import lpt_pkg::*;
#(
    parameter int CLK_KHZ    = 200_000,
    parameter int TIMEOUT_US = 10,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_mode_i,
    input  logic              auto_clr_sel_i,
    input  logic              bus_sel_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic [BYTE_W-1:0] port_data_o,
    input  logic [BYTE_W-1:0] port_data_i,
    input  logic              err_n_i,
    input  logic              online_i,
    input  logic              paper_out_i,
    input  logic              ack_n_i,
    input  logic              busy_i,
    input  logic              xfer_start_i,
    input  logic              periph_ack_i
);
    localparam int TO_CYCLES = CLK_KHZ * TIMEOUT_US / 1000;

    logic                   hit_data, hit_stat;
    logic                   wr_data, wr_stat, rd_stat;
    logic [BYTE_W-1:0]      data_q;
    logic [NUM_STAT_IN-1:0] pins_sync;
    logic                   tmo_flag, tmo_clr, trail;
    stat_t                  live_stat;
    logic [BYTE_W-1:0]      stat_view;

    assign hit_data = bus_sel_i && (bus_addr_i == ADDR_W'(OFS_DATA));
    assign hit_stat = bus_sel_i && (bus_addr_i == ADDR_W'(OFS_STAT));
    assign wr_data  = hit_data && bus_wr_i;
    assign wr_stat  = hit_stat && bus_wr_i;
    assign rd_stat  = hit_stat && bus_rd_i;

    // Output byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= bus_wdata_i;
    end
    assign port_data_o = data_q;

    lpt_sync #(.W(NUM_STAT_IN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({busy_i, ack_n_i, paper_out_i, online_i, err_n_i}),
        .q_o   (pins_sync)
    );

    // Assemble the live status byte.
    always_comb begin
        live_stat.busy      = pins_sync[4];
        live_stat.ack_n     = pins_sync[3];
        live_stat.paper_out = pins_sync[2];
        live_stat.online    = pins_sync[1];
        live_stat.err_n     = pins_sync[0];
        live_stat.zero      = 2'b00;
        live_stat.tmo       = tmo_flag;
    end

    lpt_stat_cap u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (rd_stat),
        .live_i  (live_stat),
        .view_o  (stat_view),
        .trail_o (trail)
    );

    assign tmo_clr = auto_clr_sel_i ? trail : (wr_stat && bus_wdata_i[0]);

    lpt_timeout #(.TO_CYCLES(TO_CYCLES)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .enh_i   (enh_mode_i),
        .start_i (xfer_start_i),
        .ack_i   (periph_ack_i),
        .clr_i   (tmo_clr),
        .flag_o  (tmo_flag)
    );

    // Read data mux.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && bus_rd_i) begin
            if (bus_addr_i == ADDR_W'(OFS_DATA))
                bus_rdata_o = enh_mode_i ? data_q : port_data_i;
            else if (bus_addr_i == ADDR_W'(OFS_STAT))
                bus_rdata_o = stat_view;
        end
    end

    assert_data_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (port_data_o == $past(bus_wdata_i)));
    assert_other_ofs_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !wr_data) |=> $stable(port_data_o));
    assert_stat_zero_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (bus_rdata_o[2:1] == 2'b00));
    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && bus_rd_i) |-> (bus_rdata_o == '0));
endmodule

// File: tb/lpt_host_if_tb.sv
`timescale 1ns/1ps
module lpt_host_if_tb;
    localparam int N = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enh = 1'b0, asel = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata, pout, pin = '0;
    logic       err_n = 1'b1, online = 1'b0, paper = 1'b0, ack_n = 1'b1, busy = 1'b0;
    logic       start = 1'b0, pack = 1'b0;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    lpt_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .enh_mode_i(enh), .auto_clr_sel_i(asel),
        .bus_sel_i(sel), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .port_data_o(pout),
        .port_data_i(pin), .err_n_i(err_n), .online_i(online),
        .paper_out_i(paper), .ack_n_i(ack_n), .busy_i(busy),
        .xfer_start_i(start), .periph_ack_i(pack)
    );

    // {mode, written byte, pin levels}
    localparam logic [16:0] VEC [0:5] = '{
        {1'b0, 8'hA5, 8'h5A}, {1'b0, 8'h01, 8'h80}, {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h3C, 8'hC3}, {1'b1, 8'h80, 8'h7F}, {1'b1, 8'h00, 8'hFF}};
    // {busy, ack_n, paper, online, err_n}
    localparam logic [4:0] SPAT [0:3] = '{5'b10000, 5'b01010, 5'b00101, 5'b11111};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input logic flag);
        return {busy, ack_n, paper, online, err_n, 2'b00, flag};
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    // Combinational look at a location without crossing a clock edge.
    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1; rd = 1; addr = a;
        #1 d = rdata;
        sel = 0; rd = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 output byte after reset", pout, 8'h00);
        peek(3'd1, v);
        chk("R1 flag after reset", {7'b0, v[0]}, 8'h00);

        // R2/R3: vector table walk
        for (int i = 0; i < 6; i++) begin
            enh = VEC[i][16];
            bus_write(3'd0, VEC[i][15:8]);
            chk("R2 output byte", pout, VEC[i][15:8]);
            pin = VEC[i][7:0];
            peek(3'd0, v);
            chk("R3 offset 0 read", v, VEC[i][16] ? VEC[i][15:8] : VEC[i][7:0]);
        end
        enh = 0;

        // R5: status layout
        for (int i = 0; i < 4; i++) begin
            {busy, ack_n, paper, online, err_n} = SPAT[i];
            repeat (3) @(negedge clk);
            peek(3'd1, v);
            chk("R5 status layout", v, exp_stat(1'b0));
        end

        // R5: two-flop latency on online
        @(negedge clk); online = 0;
        repeat (3) @(negedge clk);
        online = 1;
        peek(3'd1, v);
        chk("R5 not visible after one edge", {7'b0, v[4]}, 8'h00);
        peek(3'd1, v);
        chk("R5 visible after two edges", {7'b0, v[4]}, 8'h01);

        // R4: held status read
        @(negedge clk); sel = 1; rd = 1; addr = 3'd1;
        #1 v0 = rdata;
        busy = ~busy; err_n = ~err_n;
        repeat (4) @(negedge clk);
        chk("R4 frozen during read", rdata, v0);
        sel = 0; rd = 0;
        repeat (3) @(negedge clk);
        peek(3'd1, v);
        chk("R4 new read sees new inputs", v, exp_stat(1'b0));

        // R6: terminal count timing
        enh = 1; asel = 0;
        pulse_start();
        repeat (N - 2) @(negedge clk);
        peek(3'd1, v);
        chk("R6 flag clear one cycle early", {7'b0, v[0]}, 8'h00);
        peek(3'd1, v);
        chk("R6 flag set at terminal edge", {7'b0, v[0]}, 8'h01);

        // R7: write-one clear mode
        @(negedge clk); sel = 1; rd = 1; addr = 3'd1;
        @(negedge clk); sel = 0; rd = 0;
        peek(3'd1, v);
        chk("R7 read does not clear", {7'b0, v[0]}, 8'h01);
        bus_write(3'd1, 8'h00);
        peek(3'd1, v);
        chk("R7 write zero no effect", {7'b0, v[0]}, 8'h01);
        bus_write(3'd1, 8'h01);
        peek(3'd1, v);
        chk("R7 write one clears", {7'b0, v[0]}, 8'h00);

        // R6: acknowledge cancels
        pulse_start();
        repeat (10) @(negedge clk);
        pack = 1; @(negedge clk); pack = 0;
        repeat (N + 20) @(negedge clk);
        peek(3'd1, v);
        chk("R6 ack cancels timeout", {7'b0, v[0]}, 8'h00);

        // R6: compatible mode ignores start
        enh = 0;
        pulse_start();
        repeat (N + 5) @(negedge clk);
        peek(3'd1, v);
        chk("R6 compatible mode no timeout", {7'b0, v[0]}, 8'h00);

        // R8: clear at end of status read
        enh = 1; asel = 1;
        pulse_start();
        repeat (N + 5) @(negedge clk);
        bus_write(3'd1, 8'h01);
        peek(3'd1, v);
        chk("R8 write ignored in auto mode", {7'b0, v[0]}, 8'h01);
        @(negedge clk); sel = 1; rd = 1; addr = 3'd1;
        @(negedge clk);
        chk("R8 flag seen during read", {7'b0, rdata[0]}, 8'h01);
        sel = 0; rd = 0;
        peek(3'd1, v);
        chk("R8 cleared after read ends", {7'b0, v[0]}, 8'h00);

        // R9: set beats same-cycle clear
        asel = 0;
        pulse_start();
        repeat (N - 1) @(negedge clk);
        sel = 1; wr = 1; addr = 3'd1; wdata = 8'h01;
        @(negedge clk); sel = 0; wr = 0;
        peek(3'd1, v);
        chk("R9 set wins over clear", {7'b0, v[0]}, 8'h01);

        // R10: unused offsets
        bus_write(3'd0, 8'h5A);
        bus_write(3'd2, 8'hFF);
        chk("R10 write to offset 2 ignored", pout, 8'h5A);
        peek(3'd2, v);
        chk("R10 offset 2 reads zero", v, 8'h00);
        @(negedge clk); addr = 3'd1; #1;
        chk("R10 idle read data zero", rdata, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule